// File: doc/BRIEF.md
# Thermal Sample Averager with Threshold-Relative Reporting

This block takes readings from an on-die digital thermal sensor at a programmable interval and can smooth them with a fixed recursive average. Each new result gives equal weight to the previous result and to the fresh reading. The smoothed value is kept in fixed point with one fractional bit, so its least significant bit is half a degree. The block then reports the value as a signed offset from a thermal-control activation temperature. The offset is zero at or above that temperature and negative below it, saturating at the most negative value the output can hold.

The sensor side presents a temperature word with a valid strobe. The block keeps the latest reading and takes it in only when its sample timer expires. A programmable tick count sets the timer, and a count of zero falls back to a built-in default. A host poll port returns the most recently completed relative reading, whatever the ratio of polls to samples. Fan control, the serial host wire protocol and agent addressing belong to other blocks.

Top module: `thermal_avg_reporter`

## Requirements
- R1: The sample timer expires once every `interval_ticks` clock cycles. At an expiry the block accepts the latest sensor reading only if a valid reading has arrived since the previous acceptance. With a valid reading held every cycle, `new_sample` pulses exactly `interval_ticks` cycles apart.
- R2: An `interval_ticks` value of zero is treated as DEFAULT_TICKS (16400 cycles by default).
- R3: A change to `interval_ticks` does not shorten or stretch the period already running. It takes effect at the next timer reload.
- R4: With `filt_en` high and the filter already seeded, an accepted reading T updates `filt_temp` (unsigned, bit 0 = 0.5 degree) to (filt_temp + 2*T) >> 1.
- R5: The first reading accepted after reset, or after `filt_en` has been low, loads `filt_temp` = 2*T with no averaging.
- R6: With `filt_en` low, each accepted reading loads `filt_temp` = 2*T directly.
- R7: `rel_temp` is floor(filt_temp/2) minus `trip_temp` as a two's-complement integer. It is forced to 0 when that difference is zero or positive, and to -2^(REL_W-1) (-128 by default) when the difference is below that value.
- R8: `new_sample` is a one-cycle pulse in the cycle after `filt_temp` changes. `rel_temp` takes its new value in that same cycle and changes at no other time.
- R9: One cycle after `poll_req` is high, `poll_ack` is high for one cycle and `poll_data` holds the `rel_temp` value present in the request cycle.
- R10: A timer expiry with no new valid reading leaves `filt_temp` and `rel_temp` unchanged and produces no `new_sample`.
- R11: While `rst_n` is low, `filt_temp`, `rel_temp`, `poll_data`, `new_sample` and `poll_ack` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sens_temp | input | TEMP_W | Raw sensor temperature, unsigned whole degrees |
| sens_valid | input | 1 | Qualifies `sens_temp` for one cycle |
| interval_ticks | input | IW | Sample period in clock cycles; 0 selects the default |
| filt_en | input | 1 | 1 = half-weight averaging, 0 = raw pass-through |
| trip_temp | input | TEMP_W | Activation temperature, unsigned whole degrees |
| filt_temp | output | TEMP_W+1 | Filtered temperature, bit 0 = 0.5 degree |
| rel_temp | output | REL_W | Signed offset from `trip_temp`, never positive |
| new_sample | output | 1 | One-cycle pulse per completed result |
| poll_req | input | 1 | Host poll request |
| poll_ack | output | 1 | Poll response valid, one cycle after the request |
| poll_data | output | REL_W | Latest completed relative reading |

## Verification
A table of readings is run through the averager. Rising, flat, falling and overshooting inputs show whether the halving keeps or drops the fractional bit in the right place. Readings that straddle the trip point, including a value that lands exactly on it, separate a correct zero clamp from an off-by-one. Toggling the filter enable between entries shows whether the block bypasses the average and re-seeds on return, rather than blending with a stale value. Runs with a reading held valid every cycle measure strobe spacing before and after changes to the interval. Those runs catch a reload that takes a new value too early and a zero interval that is not replaced by the default. Idle expiries and repeated polls confirm that results persist when no new data arrives.

// File: rtl/thermal_avg_pkg.sv
// Package: shared default sizes for the thermal sample averager.
// Assumes a 200 MHz clock when deriving the default sample period.
package thermal_avg_pkg;
    localparam int unsigned TA_TEMP_W       = 8;      // sensor word width
    localparam int unsigned TA_REL_W        = 8;      // relative reading width
    localparam int unsigned TA_IW           = 23;     // covers 20 ms at 200 MHz
    localparam int unsigned TA_DEFAULT_TICK = 16400;  // 82 us at 200 MHz
endpackage

// File: rtl/thermal_tick_timer.sv
// Module: thermal_tick_timer
// Down-counter that raises tick_o for one cycle each time it reaches zero,
// then reloads from interval_i (zero means DEFAULT_TICKS). The interval is
// read only at reload. Assumes DEFAULT_TICKS fits in IW bits.
module thermal_tick_timer #(
    parameter int unsigned IW            = 23,
    parameter int unsigned DEFAULT_TICKS = 16400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] interval_i,
    output logic          tick_o
);
    localparam logic [IW-1:0] DEF_LOAD = IW'(DEFAULT_TICKS);

    logic [IW-1:0] cnt_q;
    logic [IW-1:0] reload;

    // Pick the reload value, replacing a zero interval with the default.
    always_comb reload = (interval_i == '0) ? DEF_LOAD : interval_i;

    assign tick_o = (cnt_q == '0);

    // Count down; reload on expiry so the period equals the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= reload - 1'b1;
        else             cnt_q <= cnt_q - 1'b1;
    end

    // R2: a zero interval at reload starts a full default-length period.
    p_zero_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && interval_i == '0) |=> (cnt_q == DEF_LOAD - 1'b1));

    // R3: between expiries the count only moves down by one, whatever the interval input does.
    p_no_midrun_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_o |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/thermal_sample_capture.sv
// Module: thermal_sample_capture
// Keeps the latest valid sensor word and a pending flag. On a timer tick with
// a pending word it issues accept_o together with that word. A reading that
// arrives in the tick cycle stays pending for the next tick.
module thermal_sample_capture #(
    parameter int unsigned TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] sens_temp_i,
    input  logic              sens_valid_i,
    input  logic              tick_i,
    output logic              accept_o,
    output logic [TEMP_W-1:0] sample_o
);
    logic [TEMP_W-1:0] last_q;
    logic              pend_q;

    assign accept_o = tick_i && pend_q;
    assign sample_o = last_q;

    // Hold the newest reading; a fresh strobe wins over consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            pend_q <= 1'b0;
        end else if (sens_valid_i) begin
            last_q <= sens_temp_i;
            pend_q <= 1'b1;
        end else if (tick_i) begin
            pend_q <= 1'b0;
        end
    end

    // R10: once a reading is consumed with no new strobe, no second acceptance follows.
    p_consume_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !sens_valid_i) |=> !pend_q);
endmodule

// File: rtl/thermal_half_filter.sv
// Module: thermal_half_filter
// Recursive half-weight average in fixed point with one fractional bit.
// Seeds directly on the first sample after reset or after a disable, and
// passes samples straight through while disabled. upd_o marks the cycle in
// which filt_o holds a freshly written value.
module thermal_half_filter #(
    parameter int unsigned TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              accept_i,
    input  logic [TEMP_W-1:0] sample_i,
    output logic [TEMP_W:0]   filt_o,
    output logic              upd_o
);
    localparam int unsigned QW = TEMP_W + 1;

    logic [QW-1:0] q_q;
    logic          seeded_q;
    logic          upd_q;
    logic [QW-1:0] samp_fx;
    logic [QW:0]   sum;
    logic [QW-1:0] avg;

    // Widen the sample to half-degree units and form the rounded-down mean.
    always_comb begin
        samp_fx = {sample_i, 1'b0};
        sum     = {1'b0, q_q} + {1'b0, samp_fx};
        avg     = sum[QW:1];
    end

    // Update the filter state on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q      <= '0;
            seeded_q <= 1'b0;
        end else begin
            if (accept_i) begin
                q_q <= (en_i && seeded_q) ? avg : samp_fx;
            end
            if (!en_i)         seeded_q <= 1'b0;
            else if (accept_i) seeded_q <= 1'b1;
        end
    end

    // Flag the cycle in which the new value is visible.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= accept_i;
    end

    assign filt_o = q_q;
    assign upd_o  = upd_q;

    // R5: an unseeded acceptance loads the sample unblended.
    p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && en_i && !seeded_q) |=> (q_q == {$past(sample_i), 1'b0}));

    // R6: bypass loads the sample unblended.
    p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && !en_i) |=> (q_q == {$past(sample_i), 1'b0}));

    // R4: a blended result lies between the old state and the new sample.
    p_avg_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && en_i && seeded_q) |=>
            ((q_q >= $past(q_q) || q_q >= {$past(sample_i), 1'b0}) &&
             (q_q <= $past(q_q) || q_q <= {$past(sample_i), 1'b0})));

    // R10: without acceptance the state holds.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(q_q));
endmodule

// File: rtl/thermal_rel_encoder.sv
// Module: thermal_rel_encoder
// Converts the filtered value into a saturated, non-positive offset from the
// trip temperature, registered together with a one-cycle strobe. Uses an
// arithmetic shift so the fractional half-degree rounds toward minus infinity.
// Assumes REL_W <= TEMP_W + 2.
module thermal_rel_encoder #(
    parameter int unsigned TEMP_W = 8,
    parameter int unsigned REL_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TEMP_W:0]         filt_i,
    input  logic [TEMP_W-1:0]       trip_i,
    input  logic                    upd_i,
    output logic signed [REL_W-1:0] rel_o,
    output logic                    strobe_o
);
    localparam int unsigned DW    = TEMP_W + 2;
    localparam int              MIN_I = -(2 ** (REL_W - 1));
    localparam logic signed [DW-1:0] RMIN = DW'(MIN_I);

    logic signed [DW-1:0]    diff2;
    logic signed [DW-1:0]    diff;
    logic signed [REL_W-1:0] rel_d;
    logic signed [REL_W-1:0] rel_q;
    logic                    strobe_q;

    // Difference in half degrees, floored to whole degrees, then clamped.
    always_comb begin
        diff2 = $signed({1'b0, filt_i}) - $signed({1'b0, trip_i, 1'b0});
        diff  = diff2 >>> 1;
        if (diff >= 0)        rel_d = '0;
        else if (diff < RMIN) rel_d = RMIN[REL_W-1:0];
        else                  rel_d = diff[REL_W-1:0];
    end

    // Publish the reading with its strobe one cycle after the filter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= upd_i;
            if (upd_i) rel_q <= rel_d;
        end
    end

    assign rel_o    = rel_q;
    assign strobe_o = strobe_q;

    // R7: the reported offset is never positive.
    p_nonpositive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q[REL_W-1] || (rel_q == '0));

    // R8: the reading changes only in a strobe cycle.
    p_rel_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_q |-> $stable(rel_q));
endmodule

// File: rtl/thermal_avg_reporter.sv
// Module: thermal_avg_reporter (top)
// Sample timer, capture, half-weight filter and relative encoder, plus a host
// poll port that returns the latest completed relative reading one cycle after
// a request. Assumes the sensor strobe and inputs are synchronous to clk.
module thermal_avg_reporter
    import thermal_avg_pkg::*;
#(
    parameter int unsigned TEMP_W        = TA_TEMP_W,
    parameter int unsigned REL_W         = TA_REL_W,
    parameter int unsigned IW            = TA_IW,
    parameter int unsigned DEFAULT_TICKS = TA_DEFAULT_TICK
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TEMP_W-1:0]       sens_temp,
    input  logic                    sens_valid,
    input  logic [IW-1:0]           interval_ticks,
    input  logic                    filt_en,
    input  logic [TEMP_W-1:0]       trip_temp,
    output logic [TEMP_W:0]         filt_temp,
    output logic signed [REL_W-1:0] rel_temp,
    output logic                    new_sample,
    input  logic                    poll_req,
    output logic                    poll_ack,
    output logic signed [REL_W-1:0] poll_data
);
    logic              tick;
    logic              accept;
    logic [TEMP_W-1:0] sample;
    logic              upd;
    logic              ack_q;
    logic signed [REL_W-1:0] pdata_q;

    thermal_tick_timer #(.IW(IW), .DEFAULT_TICKS(DEFAULT_TICKS)) timer_i (
        .clk(clk), .rst_n(rst_n), .interval_i(interval_ticks), .tick_o(tick));

    thermal_sample_capture #(.TEMP_W(TEMP_W)) capture_i (
        .clk(clk), .rst_n(rst_n), .sens_temp_i(sens_temp),
        .sens_valid_i(sens_valid), .tick_i(tick),
        .accept_o(accept), .sample_o(sample));

    thermal_half_filter #(.TEMP_W(TEMP_W)) filter_i (
        .clk(clk), .rst_n(rst_n), .en_i(filt_en), .accept_i(accept),
        .sample_i(sample), .filt_o(filt_temp), .upd_o(upd));

    thermal_rel_encoder #(.TEMP_W(TEMP_W), .REL_W(REL_W)) encoder_i (
        .clk(clk), .rst_n(rst_n), .filt_i(filt_temp), .trip_i(trip_temp),
        .upd_i(upd), .rel_o(rel_temp), .strobe_o(new_sample));

    // Answer each poll with the latest completed reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            pdata_q <= '0;
        end else begin
            ack_q <= poll_req;
            if (poll_req) pdata_q <= rel_temp;
        end
    end

    assign poll_ack  = ack_q;
    assign poll_data = pdata_q;

    // R9: a poll is answered next cycle with the reading seen at the request.
    p_poll_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> (poll_ack && poll_data == $past(rel_temp)));

    // R8: a strobe always follows a change of the filtered value's source.
    p_strobe_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        new_sample |-> $past(accept, 2));
endmodule

// File: tb/thermal_avg_reporter_tb_top.sv
`timescale 1ns/1ps
module thermal_avg_reporter_tb_top;
    localparam int TEMP_W = 8;
    localparam int REL_W  = 8;
    localparam int IW     = 23;
    localparam int DEF_T  = 16400;
    localparam int NVEC   = 16;

    // Fields: {temp[8], filt_en[1], trip[8], expected filt_temp[9], expected rel_temp[8]}
    localparam logic [33:0] VEC [NVEC] = '{
        {8'd80,  1'b1, 8'd100, 9'd160, 8'(-20)},
        {8'd90,  1'b1, 8'd100, 9'd170, 8'(-15)},
        {8'd91,  1'b1, 8'd100, 9'd176, 8'(-12)},
        {8'd100, 1'b1, 8'd100, 9'd188, 8'(-6)},
        {8'd120, 1'b1, 8'd100, 9'd214, 8'(0)},
        {8'd101, 1'b1, 8'd100, 9'd208, 8'(0)},
        {8'd99,  1'b1, 8'd100, 9'd203, 8'(0)},
        {8'd99,  1'b1, 8'd100, 9'd200, 8'(0)},
        {8'd99,  1'b1, 8'd100, 9'd199, 8'(-1)},
        {8'd10,  1'b0, 8'd100, 9'd20,  8'(-90)},
        {8'd200, 1'b0, 8'd100, 9'd400, 8'(0)},
        {8'd50,  1'b1, 8'd100, 9'd100, 8'(-50)},
        {8'd52,  1'b1, 8'd100, 9'd102, 8'(-49)},
        {8'd0,   1'b0, 8'd255, 9'd0,   8'(-128)},
        {8'd0,   1'b0, 8'd128, 9'd0,   8'(-128)},
        {8'd0,   1'b0, 8'd127, 9'd0,   8'(-127)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TEMP_W-1:0] sens_temp = '0;
    logic sens_valid = 1'b0;
    logic [IW-1:0] interval_ticks = IW'(8);
    logic filt_en = 1'b1;
    logic [TEMP_W-1:0] trip_temp = 8'd100;
    logic [TEMP_W:0] filt_temp;
    logic signed [REL_W-1:0] rel_temp;
    logic new_sample;
    logic poll_req = 1'b0;
    logic poll_ack;
    logic signed [REL_W-1:0] poll_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    thermal_avg_reporter #(.TEMP_W(TEMP_W), .REL_W(REL_W), .IW(IW), .DEFAULT_TICKS(DEF_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .sens_temp(sens_temp), .sens_valid(sens_valid),
        .interval_ticks(interval_ticks), .filt_en(filt_en), .trip_temp(trip_temp),
        .filt_temp(filt_temp), .rel_temp(rel_temp), .new_sample(new_sample),
        .poll_req(poll_req), .poll_ack(poll_ack), .poll_data(poll_data));

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Count negedges until the next strobe; returns -1 past the limit.
    task automatic gap_to_strobe(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!new_sample && n < 20000);
        if (!new_sample) n = -1;
    endtask

    initial begin
        int g;
        int held_q;
        int held_r;
        int strobes;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(filt_temp == 0, "R11 filt_temp in reset", int'(filt_temp), 0);
        chk(rel_temp == 0, "R11 rel_temp in reset", int'(rel_temp), 0);
        chk(!new_sample && !poll_ack, "R11 strobes in reset", int'({new_sample, poll_ack}), 0);
        chk(poll_data == 0, "R11 poll_data in reset", int'(poll_data), 0);
        rst_n = 1'b1;

        // Vector table: R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            sens_temp  = VEC[i][33:26];
            filt_en    = VEC[i][25];
            trip_temp  = VEC[i][24:17];
            sens_valid = 1'b1;
            @(negedge clk);
            sens_valid = 1'b0;
            gap_to_strobe(g);
            chk(g > 0, $sformatf("R1 strobe for vector %0d", i), g, 1);
            chk(filt_temp == VEC[i][16:8], $sformatf("R4 R5 R6 filt vector %0d", i),
                int'(filt_temp), int'(VEC[i][16:8]));
            chk(rel_temp == $signed(VEC[i][7:0]), $sformatf("R7 rel vector %0d", i),
                int'(rel_temp), int'($signed(VEC[i][7:0])));
            @(negedge clk);
            chk(!new_sample, $sformatf("R8 single-cycle strobe vector %0d", i), int'(new_sample), 0);
        end

        // R10: idle expiries change nothing
        held_q = int'(filt_temp);
        held_r = int'(rel_temp);
        strobes = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (new_sample) strobes++;
        end
        chk(strobes == 0, "R10 no strobe without reading", strobes, 0);
        chk(int'(filt_temp) == held_q, "R10 filt held", int'(filt_temp), held_q);
        chk(int'(rel_temp) == held_r, "R10 rel held", int'(rel_temp), held_r);

        // R9: polls return the latest reading, repeatedly
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            poll_req = 1'b1;
            @(negedge clk);
            poll_req = 1'b0;
            chk(poll_ack, "R9 poll_ack", int'(poll_ack), 1);
            chk(poll_data == -127, "R9 poll_data", int'(poll_data), -127);
            @(negedge clk);
            chk(!poll_ack, "R9 poll_ack one cycle", int'(poll_ack), 0);
        end

        // R1 R3 R2: strobe spacing with a reading held valid every cycle
        sens_temp = 8'd50;
        filt_en = 1'b0;
        sens_valid = 1'b1;
        gap_to_strobe(g);
        gap_to_strobe(g);
        chk(g == 8, "R1 period of 8", g, 8);
        interval_ticks = IW'(5);
        gap_to_strobe(g);
        chk(g == 8, "R3 running period kept", g, 8);
        gap_to_strobe(g);
        chk(g == 5, "R3 new period after reload", g, 5);
        interval_ticks = '0;
        gap_to_strobe(g);
        chk(g == 5, "R3 running period kept before zero", g, 5);
        gap_to_strobe(g);
        chk(g == DEF_T, "R2 zero interval uses default", g, DEF_T);
        sens_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule